// File: doc/BRIEF.md
# Operand Compare and Status Flag Unit

This block compares two integer operands by subtracting the second from the first. It keeps only the status flags that the subtraction produces and throws the difference away. The first operand always comes from a register. The second operand comes either from a register or from a short immediate. The immediate is sign-extended to the operand size before use. The operand size can be 8, 16 or 32 bits.

Six flags are produced, the same way a plain subtract would produce them: borrow (carry), signed overflow, sign, zero, nibble borrow (auxiliary carry) and low-byte parity. They are computed combinationally from the operands. A flag register captures them on a clock edge when the valid strobe is high. The surrounding pipeline raises the strobe for each compare it issues and reads the six flag outputs from the following cycle on.

The datapath is a straight chain with no sequencing, so the block has no state machine. Its only state is the flag register, which has two behaviours: it loads when the strobe is high and holds when the strobe is low.

Top module: `cmp_flag_unit`

## Requirements
- R1: The unit evaluates first operand minus second operand at the size picked by `size_i`: 00 gives 8 bits, 01 gives 16 bits, and 10 or 11 give 32 bits. Operand bits above the selected size have no effect on any flag.
- R2: `cf_o` is 1 when the first operand is less than the second, with both taken as unsigned at the selected size.
- R3: `of_o` is 1 only when the two operands differ in their top bit at the selected size and the result's top bit differs from the first operand's top bit.
- R4: `sf_o` equals the top bit of the result at the selected size. `zf_o` is 1 exactly when every result bit at that size is 0.
- R5: `af_o` is 1 when bits 3..0 of the first operand, taken as unsigned, are less than bits 3..0 of the second, which is a borrow out of bit 3.
- R6: `pf_o` is 1 when result bits 7..0 hold an even number of ones, for every size.
- R7: When `use_imm_i` is 1, the second operand is `imm_i` sign-extended to the selected size, and `src2_i` has no effect.
- R8: The flag outputs take new values only on a rising clock edge where `valid_i` is 1. They change one cycle after the strobe and hold otherwise.
- R9: While `rst_n` is low, all six flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare strobe; loads the flag register |
| size_i | input | 2 | Operand size: 00=8, 01=16, 10/11=32 bits |
| use_imm_i | input | 1 | 1 selects the immediate as second operand |
| src1_i | input | 32 | First operand |
| src2_i | input | 32 | Register second operand |
| imm_i | input | IMM_W (8) | Immediate second operand, signed |
| cf_o | output | 1 | Borrow flag |
| of_o | output | 1 | Signed overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Nibble borrow flag |
| pf_o | output | 1 | Low-byte even parity flag |

## Verification
The compare is driven with seeded random operands at every size, for both register and immediate sources. Random values set the upper bits above the selected size, so any leakage of those bits into the flags shows up. Directed pairs test specific cases:
- Equal operands separate zero detection from borrow.
- The most-negative value minus one, and zero minus one, separate signed overflow from unsigned borrow.
- Negative immediates show whether sign extension reaches the top bit at 16 and 32 bits.
- Compares with the strobe low, and immediate compares whose register operand changes, show that the held flags and the ignored input leave the outputs unchanged.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;
    parameter int OPW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } op_size_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } flags_t;

    function automatic logic [OPW-1:0] size_mask(input op_size_e sz);
        logic [OPW-1:0] m;
        unique case (sz)
            SZ_BYTE: m = OPW'(8'hFF);
            SZ_HALF: m = OPW'(16'hFFFF);
            default: m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/cmp_operand_sel.sv
module cmp_operand_sel
    import cmp_flag_pkg::*;
#(
    parameter int IMM_W = 8
) (
    input  op_size_e           size_i,
    input  logic               use_imm_i,
    input  logic [OPW-1:0]     src1_i,
    input  logic [OPW-1:0]     src2_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic [OPW-1:0]     opa_o,
    output logic [OPW-1:0]     opb_o
);
    localparam int EXT_W = OPW - IMM_W;

    logic [OPW-1:0] imm_ext;
    logic [OPW-1:0] mask;

    always_comb begin
        imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        mask    = size_mask(size_i);
        opa_o   = src1_i & mask;
        opb_o   = (use_imm_i ? imm_ext : src2_i) & mask;
    end
endmodule

// File: rtl/cmp_flag_calc.sv
module cmp_flag_calc
    import cmp_flag_pkg::*;
(
    input  op_size_e       size_i,
    input  logic [OPW-1:0] opa_i,
    input  logic [OPW-1:0] opb_i,
    output flags_t         flags_o
);
    logic [OPW-1:0] diff;
    logic           a_top;
    logic           b_top;
    logic           r_top;

    always_comb begin
        diff = opa_i - opb_i;
        unique case (size_i)
            SZ_BYTE: begin a_top = opa_i[7];  b_top = opb_i[7];  r_top = diff[7];  end
            SZ_HALF: begin a_top = opa_i[15]; b_top = opb_i[15]; r_top = diff[15]; end
            default: begin
                a_top = opa_i[OPW-1]; b_top = opb_i[OPW-1]; r_top = diff[OPW-1];
            end
        endcase
        flags_o.cf = opa_i < opb_i;
        flags_o.of = (a_top != b_top) && (r_top != a_top);
        flags_o.sf = r_top;
        flags_o.zf = (diff & size_mask(size_i)) == '0;
        flags_o.af = opa_i[3:0] < opb_i[3:0];
        flags_o.pf = ~^diff[7:0];
    end
endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg
    import cmp_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  flags_t next_i,
    output flags_t flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_o <= '0;
        else if (load_i)
            flags_o <= next_i;
    end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmp_flag_pkg::*;
#(
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [1:0]       size_i,
    input  logic             use_imm_i,
    input  logic [31:0]      src1_i,
    input  logic [31:0]      src2_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic             cf_o,
    output logic             of_o,
    output logic             sf_o,
    output logic             zf_o,
    output logic             af_o,
    output logic             pf_o
);
    op_size_e       size_e;
    logic [OPW-1:0] opa;
    logic [OPW-1:0] opb;
    flags_t         next_flags;
    flags_t         cur_flags;

    assign size_e = op_size_e'(size_i);

    cmp_operand_sel #(.IMM_W(IMM_W)) u_sel (
        .size_i    (size_e),
        .use_imm_i (use_imm_i),
        .src1_i    (src1_i),
        .src2_i    (src2_i),
        .imm_i     (imm_i),
        .opa_o     (opa),
        .opb_o     (opb)
    );

    cmp_flag_calc u_calc (
        .size_i  (size_e),
        .opa_i   (opa),
        .opb_i   (opb),
        .flags_o (next_flags)
    );

    cmp_flag_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (valid_i),
        .next_i  (next_flags),
        .flags_o (cur_flags)
    );

    assign cf_o = cur_flags.cf;
    assign of_o = cur_flags.of;
    assign sf_o = cur_flags.sf;
    assign zf_o = cur_flags.zf;
    assign af_o = cur_flags.af;
    assign pf_o = cur_flags.pf;
endmodule

// File: rtl/cmp_flag_checker.sv
module cmp_flag_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [1:0]  size_i,
    input logic        use_imm_i,
    input logic [31:0] src1_i,
    input logic [31:0] src2_i,
    input logic        cf_o,
    input logic        of_o,
    input logic        sf_o,
    input logic        zf_o,
    input logic        af_o,
    input logic        pf_o
);
    logic [5:0] flags;
    assign flags = {cf_o, of_o, sf_o, zf_o, af_o, pf_o};

    // R8: flags hold when no strobe
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags));

    // R4: equal 32-bit register operands give zero result
    p_equal_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && size_i[1] && src1_i == src2_i)
        |=> (zf_o && !cf_o && !of_o && !sf_o && !af_o && pf_o));

    // R2: unsigned 32-bit less-than gives borrow
    p_borrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && size_i[1] && src1_i < src2_i) |=> cf_o);

    // R5: low-nibble borrow at any size
    p_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i) |=> (af_o == ($past(src1_i[3:0]) < $past(src2_i[3:0]))));

    // R3: same-sign byte operands never overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && size_i == 2'b00 && src1_i[7] == src2_i[7]) |=> !of_o);
endmodule

bind cmp_flag_unit cmp_flag_checker u_cmp_flag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .size_i    (size_i),
    .use_imm_i (use_imm_i),
    .src1_i    (src1_i),
    .src2_i    (src2_i),
    .cf_o      (cf_o),
    .of_o      (of_o),
    .sf_o      (sf_o),
    .zf_o      (zf_o),
    .af_o      (af_o),
    .pf_o      (pf_o)
);

// File: tb/test_cmp_flag_unit.sv
`timescale 1ns/1ps
module test_cmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] src1_i = '0;
    logic [31:0] src2_i = '0;
    logic [7:0]  imm_i = '0;
    logic cf_o, of_o, sf_o, zf_o, af_o, pf_o;

    int n_checks = 0;
    int n_fails = 0;
    int seed_v;

    always #2 clk = ~clk;

    cmp_flag_unit i_cmp_flag_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .size_i(size_i),
        .use_imm_i(use_imm_i), .src1_i(src1_i), .src2_i(src2_i), .imm_i(imm_i),
        .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .pf_o(pf_o)
    );

    // expected {cf,of,sf,zf,af,pf}
    function automatic logic [5:0] model(input logic [31:0] a, input logic [31:0] b_reg,
                                         input logic [7:0] imm, input logic ui,
                                         input logic [1:0] sz);
        int w;
        logic [63:0] mask, am, bm, bsrc, r;
        logic cf, of, sf, zf, af, pf;
        w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        bsrc = ui ? {{56{imm[7]}}, imm} : {32'd0, b_reg};
        am   = {32'd0, a} & mask;
        bm   = bsrc & mask;
        r    = (am - bm) & mask;
        cf   = am < bm;
        sf   = r[w-1];
        zf   = (r == 64'd0);
        of   = (am[w-1] != bm[w-1]) && (r[w-1] != am[w-1]);
        af   = am[3:0] < bm[3:0];
        pf   = ~^r[7:0];
        return {cf, of, sf, zf, af, pf};
    endfunction

    task automatic check_bit(input string req, input string name,
                             input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, name, act, exp);
        end
    endtask

    task automatic check_all(input string ctx, input logic [5:0] exp);
        check_bit({ctx, " R2"}, "cf", cf_o, exp[5]);
        check_bit({ctx, " R3"}, "of", of_o, exp[4]);
        check_bit({ctx, " R4"}, "sf", sf_o, exp[3]);
        check_bit({ctx, " R4"}, "zf", zf_o, exp[2]);
        check_bit({ctx, " R5"}, "af", af_o, exp[1]);
        check_bit({ctx, " R6"}, "pf", pf_o, exp[0]);
    endtask

    // drive at negedge, register loads at next posedge, sample at following negedge
    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input logic [7:0] imm,
                          input logic ui, input logic [1:0] sz, input logic v,
                          output logic [5:0] obs);
        src1_i = a; src2_i = b; imm_i = imm; use_imm_i = ui; size_i = sz; valid_i = v;
        @(negedge clk);
        valid_i = 1'b0;
        obs = {cf_o, of_o, sf_o, zf_o, af_o, pf_o};
    endtask

    task automatic run_cmp(input string ctx, input logic [31:0] a, input logic [31:0] b,
                           input logic [7:0] imm, input logic ui, input logic [1:0] sz);
        logic [5:0] obs;
        do_cmp(a, b, imm, ui, sz, 1'b1, obs);
        check_all(ctx, model(a, b, imm, ui, sz));
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [5:0] obs, held;
        seed_v = 32'h1234_5678;
        void'($urandom(seed_v));
        repeat (3) @(negedge clk);
        // R9: reset state
        check_bit("R9", "flags", |{cf_o, of_o, sf_o, zf_o, af_o, pf_o}, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_cmp("R1 byte min-1",   32'h0000_0080, 32'h0000_0001, 8'h00, 1'b0, 2'b00);
        run_cmp("R2 zero-1",       32'h0000_0000, 32'h0000_0001, 8'h00, 1'b0, 2'b00);
        run_cmp("R4 equal word",   32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'h00, 1'b0, 2'b10);
        run_cmp("R3 word min-1",   32'h8000_0000, 32'h0000_0001, 8'h00, 1'b0, 2'b11);
        run_cmp("R3 half pos-neg", 32'h0000_7FFF, 32'h0000_FFFF, 8'h00, 1'b0, 2'b01);
        run_cmp("R1 upper ignored",32'hFFFF_FF05, 32'h1234_0005, 8'h00, 1'b0, 2'b00);
        check_bit("R1", "zf upper ignored", zf_o, 1'b1);
        run_cmp("R7 imm -1 word",  32'hFFFF_FFFF, 32'h0000_0000, 8'hFF, 1'b1, 2'b10);
        check_bit("R7", "zf sext word", zf_o, 1'b1);
        run_cmp("R7 imm -128 half",32'h0000_FF80, 32'h0000_0000, 8'h80, 1'b1, 2'b01);
        check_bit("R7", "zf sext half", zf_o, 1'b1);

        // R7: src2 ignored under immediate
        do_cmp(32'h0000_1234, 32'h0000_0000, 8'h35, 1'b1, 2'b01, 1'b1, held);
        do_cmp(32'h0000_1234, 32'hFFFF_FFFF, 8'h35, 1'b1, 2'b01, 1'b1, obs);
        check_bit("R7", "src2 ignored", obs == held, 1'b1);

        // R8: strobe low keeps flags
        run_cmp("R8 load", 32'h0000_0001, 32'h0000_0002, 8'h00, 1'b0, 2'b10);
        held = {cf_o, of_o, sf_o, zf_o, af_o, pf_o};
        do_cmp(32'h0000_0005, 32'h0000_0005, 8'h00, 1'b0, 2'b10, 1'b0, obs);
        check_bit("R8", "hold no strobe", obs == held, 1'b1);
        @(negedge clk);
        check_bit("R8", "hold second cycle",
                  {cf_o, of_o, sf_o, zf_o, af_o, pf_o} == held, 1'b1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            logic [7:0]  imm;
            logic        ui;
            logic [1:0]  sz;
            a   = $urandom();
            b   = ($urandom() % 4 == 0) ? a ^ ($urandom() & 32'h0000_000F) : $urandom();
            imm = $urandom();
            ui  = ($urandom() % 3 == 0);
            sz  = $urandom();
            run_cmp("rand R1", a, b, imm, ui, sz);
        end

        // R9: reset clears again
        rst_n = 1'b0;
        #1;
        check_bit("R9", "flags async reset", |{cf_o, of_o, sf_o, zf_o, af_o, pf_o}, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule